// File: doc/BRIEF.md
# SPI Serial EEPROM Command Engine

This block is the slave side of a small serial nonvolatile memory on an SPI bus (clock idle low or high, data captured on the rising serial clock edge). A host selects the block with an active-low select, shifts in a one-byte command, optionally a two-byte address and data bytes, and reads back array or status data on the serial output. The storage is a behavioural 1024-byte register array held inside the block. Array writes are never applied directly. Incoming bytes are collected in a page buffer and committed by a self-timed write period that runs on the system clock.

All three bus inputs are brought into the system clock domain through two-flop synchronisers, and edges are found by comparing the synchronised value with its previous sample. The serial clock therefore has to run at no more than a quarter of the system clock rate. A host must set the write-enable latch before each write. The latch clears itself when the write period ends.

Top module: `spi_eeprom_engine`

## Requirements
- R1: After reset, no command takes effect until the select has been seen high and then low. A command that is shifted while the select is held low straight through reset release has no effect.
- R2: Command byte 0x06 sets the write-enable latch and 0x04 clears it. Each one acts only when the select rises after exactly 8 bits. Command 0x05 returns the status byte: bit 1 is the write-enable latch, bit 0 is the busy flag, and all other bits are 0.
- R3: Command 0x03 followed by a 16-bit address returns array bytes MSB first. The output changes after falling serial clock edges. The upper 6 address bits are ignored.
- R4: During a streaming read the address advances after each output byte, and it wraps from 0x3FF to 0x000.
- R5: Command 0x02 (write) is ignored when the write-enable latch is clear. The array is unchanged and no busy period starts.
- R6: Write data bytes fill consecutive addresses within one 16-byte page. After the last byte of the page the address wraps to the first byte of the same page.
- R7: A write commits only if the select rises after at least one complete data byte with no extra bits. Otherwise it is abandoned: the array is unchanged, no busy period starts and the latch keeps its value.
- R8: A committed write holds wr_busy high for exactly WR_CYCLES system clocks, beginning just after the select rise. During that time status reads work, read, write and latch commands are ignored, and when it ends the write-enable latch is cleared.
- R9: The serial output enable is low whenever the block is deselected, and high during an active selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Output enable for spi_miso (low means high impedance) |
| wr_busy | output | 1 | High during the self-timed write period |

## Verification
The hardest state to reach from the pins is a second session that arrives while a write is still in progress. The bench lengthens the write period so that a whole write command and a latch-set command both fit inside it. It then shows, after the period ends, that the target byte kept its old value and that the latch reads clear. Abandoned writes need a select rise part way through a byte. The bench gets there by sending a few loose bits after a full data byte, and separately by sending an address with no data.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;

  localparam logic [7:0] OP_WR_STAT  = 8'h01;
  localparam logic [7:0] OP_WR_ARRAY = 8'h02;
  localparam logic [7:0] OP_RD_ARRAY = 8'h03;
  localparam logic [7:0] OP_CLR_WE   = 8'h04;
  localparam logic [7:0] OP_RD_STAT  = 8'h05;
  localparam logic [7:0] OP_SET_WE   = 8'h06;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_RD_DATA,
    ST_STATUS,
    ST_WR_DATA,
    ST_LATCH,
    ST_DROP
  } eng_state_e;

endpackage

// File: rtl/eeprom_pin_sync.sv
module eeprom_pin_sync #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/eeprom_wr_timer.sv
module eeprom_wr_timer #(
  parameter int WR_CYCLES  = 64,
  parameter int PAGE_BYTES = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  output logic                              busy,
  output logic                              done,
  output logic                              step_en,
  output logic [$clog2(PAGE_BYTES)-1:0]     step_idx
);
  localparam int CNT_W  = $clog2(WR_CYCLES + 1);
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              busy_q, busy_n;
  logic [PAGE_W:0]   idx_q, idx_n;

  always_comb begin
    cnt_n  = cnt_q;
    busy_n = busy_q;
    idx_n  = idx_q;
    if (start && !busy_q) begin
      busy_n = 1'b1;
      cnt_n  = CNT_W'(WR_CYCLES - 1);
      idx_n  = '0;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_n = 1'b0;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
      if (!idx_q[PAGE_W]) begin
        idx_n = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
      idx_q  <= idx_n;
    end
  end

  assign busy     = busy_q;
  assign done     = busy_q && (cnt_q == '0);
  assign step_en  = busy_q && !idx_q[PAGE_W];
  assign step_idx = idx_q[PAGE_W-1:0];
endmodule

// File: rtl/spi_eeprom_engine.sv
module spi_eeprom_engine
  import spi_eeprom_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe,
  output logic wr_busy
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int HI_W   = ADDR_W - 8;
  localparam int BASE_W = ADDR_W - PAGE_W;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // pin synchronisers and edge detection
  logic [2:0] pins_s;
  logic       sck_s, cs_s, mosi_s;
  logic       sck_d_q, cs_d_q;
  logic       sck_rise, sck_fall, cs_rise, cs_fall;

  eeprom_pin_sync #(.WIDTH(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({spi_mosi, spi_cs_n, spi_sck}),
    .q     (pins_s)
  );

  assign sck_s  = pins_s[0];
  assign cs_s   = pins_s[1];
  assign mosi_s = pins_s[2];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sck_d_q <= 1'b0;
      cs_d_q  <= 1'b0;
    end else begin
      sck_d_q <= sck_s;
      cs_d_q  <= cs_s;
    end
  end

  assign sck_rise = sck_s & ~sck_d_q;
  assign sck_fall = ~sck_s & sck_d_q;
  assign cs_rise  = cs_s & ~cs_d_q;
  assign cs_fall  = ~cs_s & cs_d_q;

  // engine state
  eng_state_e        state_q, state_n;
  logic              active_q, active_n;
  logic [2:0]        bit_cnt_q, bit_cnt_n;
  logic [6:0]        in_sh_q, in_sh_n;
  logic [HI_W-1:0]   addr_hi_q, addr_hi_n;
  logic [ADDR_W-1:0] ptr_q, ptr_n;
  logic [7:0]        out_sh_q, out_sh_n;
  logic [2:0]        out_cnt_q, out_cnt_n;
  logic              miso_q, miso_n;
  logic              wel_q, wel_n;
  logic              set_q, set_n;
  logic              wr_mode_q, wr_mode_n;
  logic              got_q, got_n;
  logic [BASE_W-1:0] base_q, base_n;

  logic              pb_we;
  logic [PAGE_W-1:0] pb_idx;
  logic              vmask_clr;
  logic              wr_start;
  logic [7:0]        in_byte;
  logic [7:0]        src_byte;
  logic [7:0]        arr_rdata;
  logic [PAGE_W-1:0] off_nx;

  logic              t_busy, t_done, t_step_en;
  logic [PAGE_W-1:0] t_step_idx;

  assign in_byte  = {in_sh_q, mosi_s};
  assign off_nx   = ptr_q[PAGE_W-1:0] + {{(PAGE_W-1){1'b0}}, 1'b1};
  assign src_byte = (state_q == ST_STATUS) ? {6'b0, wel_q, t_busy} : arr_rdata;

  always_comb begin
    state_n   = state_q;
    active_n  = active_q;
    bit_cnt_n = bit_cnt_q;
    in_sh_n   = in_sh_q;
    addr_hi_n = addr_hi_q;
    ptr_n     = ptr_q;
    out_sh_n  = out_sh_q;
    out_cnt_n = out_cnt_q;
    miso_n    = miso_q;
    wel_n     = wel_q;
    set_n     = set_q;
    wr_mode_n = wr_mode_q;
    got_n     = got_q;
    base_n    = base_q;
    pb_we     = 1'b0;
    pb_idx    = ptr_q[PAGE_W-1:0];
    vmask_clr = 1'b0;
    wr_start  = 1'b0;

    if (cs_fall) begin
      active_n  = 1'b1;
      state_n   = ST_CMD;
      bit_cnt_n = '0;
      out_cnt_n = '0;
      got_n     = 1'b0;
      miso_n    = 1'b0;
    end else if (cs_rise) begin
      active_n = 1'b0;
      state_n  = ST_IDLE;
      if (active_q && (bit_cnt_q == 3'd0)) begin
        if (state_q == ST_LATCH) begin
          wel_n = set_q;
        end
        if ((state_q == ST_WR_DATA) && got_q) begin
          wr_start = 1'b1;
          base_n   = ptr_q[ADDR_W-1:PAGE_W];
        end
      end
    end else if (active_q) begin
      if (sck_rise) begin
        bit_cnt_n = bit_cnt_q + 3'd1;
        in_sh_n   = {in_sh_q[5:0], mosi_s};
        if (bit_cnt_q == 3'd7) begin
          case (state_q)
            ST_CMD: begin
              case (in_byte)
                OP_RD_ARRAY: begin
                  state_n   = t_busy ? ST_DROP : ST_ADDR_HI;
                  wr_mode_n = 1'b0;
                end
                OP_WR_ARRAY: begin
                  state_n   = (t_busy || !wel_q) ? ST_DROP : ST_ADDR_HI;
                  wr_mode_n = 1'b1;
                end
                OP_RD_STAT: state_n = ST_STATUS;
                OP_SET_WE: begin
                  state_n = t_busy ? ST_DROP : ST_LATCH;
                  set_n   = 1'b1;
                end
                OP_CLR_WE: begin
                  state_n = t_busy ? ST_DROP : ST_LATCH;
                  set_n   = 1'b0;
                end
                default: state_n = ST_DROP;
              endcase
            end
            ST_ADDR_HI: begin
              addr_hi_n = in_byte[HI_W-1:0];
              state_n   = ST_ADDR_LO;
            end
            ST_ADDR_LO: begin
              ptr_n = {addr_hi_q, in_byte};
              if (wr_mode_q) begin
                state_n   = ST_WR_DATA;
                vmask_clr = 1'b1;
              end else begin
                state_n = ST_RD_DATA;
              end
            end
            ST_WR_DATA: begin
              pb_we = 1'b1;
              got_n = 1'b1;
              ptr_n = {ptr_q[ADDR_W-1:PAGE_W], off_nx};
            end
            ST_LATCH: state_n = ST_DROP;
            default: ;
          endcase
        end
      end else if (sck_fall && ((state_q == ST_RD_DATA) || (state_q == ST_STATUS))) begin
        out_cnt_n = out_cnt_q + 3'd1;
        if (out_cnt_q == 3'd0) begin
          miso_n   = src_byte[7];
          out_sh_n = {src_byte[6:0], 1'b0};
        end else begin
          miso_n   = out_sh_q[7];
          out_sh_n = {out_sh_q[6:0], 1'b0};
        end
        if ((out_cnt_q == 3'd7) && (state_q == ST_RD_DATA)) begin
          ptr_n = ptr_q + 1'b1;
        end
      end
    end

    if (t_done) begin
      wel_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q   <= ST_IDLE;
      active_q  <= 1'b0;
      bit_cnt_q <= '0;
      in_sh_q   <= '0;
      addr_hi_q <= '0;
      ptr_q     <= '0;
      out_sh_q  <= '0;
      out_cnt_q <= '0;
      miso_q    <= 1'b0;
      wel_q     <= 1'b0;
      set_q     <= 1'b0;
      wr_mode_q <= 1'b0;
      got_q     <= 1'b0;
      base_q    <= '0;
    end else begin
      state_q   <= state_n;
      active_q  <= active_n;
      bit_cnt_q <= bit_cnt_n;
      in_sh_q   <= in_sh_n;
      addr_hi_q <= addr_hi_n;
      ptr_q     <= ptr_n;
      out_sh_q  <= out_sh_n;
      out_cnt_q <= out_cnt_n;
      miso_q    <= miso_n;
      wel_q     <= wel_n;
      set_q     <= set_n;
      wr_mode_q <= wr_mode_n;
      got_q     <= got_n;
      base_q    <= base_n;
    end
  end

  // page buffer: data without reset, valid mask with reset
  logic [7:0]            pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vmask_q;

  always_ff @(posedge clk) begin
    if (pb_we) begin
      pbuf[pb_idx] <= in_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vmask_q <= '0;
    end else if (vmask_clr) begin
      vmask_q <= '0;
    end else if (pb_we) begin
      vmask_q[pb_idx] <= 1'b1;
    end
  end

  eeprom_wr_timer #(
    .WR_CYCLES  (WR_CYCLES),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (wr_start),
    .busy     (t_busy),
    .done     (t_done),
    .step_en  (t_step_en),
    .step_idx (t_step_idx)
  );

  logic mem_we;
  assign mem_we = t_step_en && vmask_q[t_step_idx];

  eeprom_array #(.ADDR_W(ADDR_W)) u_array (
    .clk   (clk),
    .we    (mem_we),
    .waddr ({base_q, t_step_idx}),
    .wdata (pbuf[t_step_idx]),
    .raddr (ptr_q),
    .rdata (arr_rdata)
  );

  assign spi_miso    = miso_q;
  assign spi_miso_oe = active_q;
  assign wr_busy     = t_busy;
endmodule

// File: rtl/spi_eeprom_engine_checker.sv
module spi_eeprom_engine_checker #(
  parameter int WR_CYCLES = 64
) (
  input logic clk,
  input logic rst_n,
  input logic wr_busy,
  input logic spi_miso_oe,
  input logic wel,
  input logic cs_hi,
  input logic cs_rise,
  input logic mem_we
);
  int busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_run <= 0;
    end else if (wr_busy) begin
      busy_run <= busy_run + 1;
    end else begin
      busy_run <= 0;
    end
  end

  // R8: busy period length
  a_r8_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_busy) |-> (busy_run == WR_CYCLES));

  a_r8_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |-> (busy_run < WR_CYCLES));

  // R8: latch is clear when the busy period ends
  a_r8_latch_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_busy) |-> !wel);

  // R8: the array is written only inside a busy period
  a_r8_array_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wr_busy);

  // R7: a busy period starts only from a select rise
  a_r7_start_on_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_busy) |-> $past(cs_rise));

  // R2: latch moves only on a select rise or at the end of a write
  a_r2_latch_moves: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wel) |-> ($past(cs_rise) || $fell(wr_busy)));

  // R9: output enable off once deselected
  a_r9_oe_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_hi && $past(cs_hi)) |-> !spi_miso_oe);
endmodule

bind spi_eeprom_engine spi_eeprom_engine_checker #(.WR_CYCLES(WR_CYCLES)) u_checker (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .wr_busy     (wr_busy),
  .spi_miso_oe (spi_miso_oe),
  .wel         (wel_q),
  .cs_hi       (cs_s),
  .cs_rise     (cs_rise),
  .mem_we      (mem_we)
);

// File: tb/spi_eeprom_engine_bench.sv
module spi_eeprom_engine_bench;
  localparam int WR_CYCLES = 600;
  localparam int HALF      = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, sck, cs_n, mosi, miso, miso_oe, busy;

  spi_eeprom_engine #(
    .ADDR_W     (10),
    .PAGE_BYTES (16),
    .WR_CYCLES  (WR_CYCLES)
  ) u_spi_eeprom_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_sck     (sck),
    .spi_cs_n    (cs_n),
    .spi_mosi    (mosi),
    .spi_miso    (miso),
    .spi_miso_oe (miso_oe),
    .wr_busy     (busy)
  );

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    string      req;
    logic [7:0] val;
  } exp_t;

  exp_t       exp_q[$];
  logic [7:0] rx_q[$];
  logic [7:0] ref_m [int];

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: pairs received bytes with expected items
  always @(negedge clk) begin
    if (rx_q.size() > 0) begin
      logic [7:0] got;
      exp_t       e;
      got = rx_q.pop_front();
      if (exp_q.size() == 0) begin
        chk("scoreboard", 1'b0, got, 0);
      end else begin
        e = exp_q.pop_front();
        chk(e.req, got === e.val, got, e.val);
      end
    end
  end

  // busy-run length monitor
  int busy_run = 0;
  int last_run = 0;
  always @(negedge clk) begin
    if (busy === 1'b1) begin
      busy_run++;
    end else if (busy_run != 0) begin
      last_run = busy_run;
      busy_run = 0;
    end
  end

  task automatic cs_low();
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_high();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic spi_bits(input int n, input logic v);
    for (int i = 0; i < n; i++) begin
      mosi = v;
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] rx;
    spi_byte(tx, rx);
  endtask

  task automatic cmd1(input logic [7:0] op);
    cs_low();
    send(op);
    cs_high();
  endtask

  task automatic rd_status(input string req, input logic [7:0] expv);
    logic [7:0] rx;
    exp_q.push_back('{req, expv});
    cs_low();
    send(8'h05);
    spi_byte(8'h00, rx);
    rx_q.push_back(rx);
    cs_high();
  endtask

  task automatic rd_array(input string req, input int addr, input int n);
    logic [7:0] rx;
    cs_low();
    send(8'h03);
    send(addr[15:8]);
    send(addr[7:0]);
    for (int k = 0; k < n; k++) begin
      int a;
      a = (addr + k) & 32'h3FF;
      spi_byte(8'h00, rx);
      if (k == 0) chk("R9", miso_oe === 1'b1, miso_oe, 1);
      if (ref_m.exists(a)) begin
        exp_q.push_back('{req, ref_m[a]});
        rx_q.push_back(rx);
      end
    end
    cs_high();
    chk("R9", miso_oe === 1'b0, miso_oe, 0);
  endtask

  // page write; commit=1 updates the reference model with page wrap
  task automatic wr_array(input int addr, input logic [7:0] d [16], input int n,
                          input bit commit);
    cs_low();
    send(8'h02);
    send(addr[15:8]);
    send(addr[7:0]);
    for (int k = 0; k < n; k++) begin
      send(d[k]);
      if (commit) begin
        ref_m[(addr & 32'h3F0) | ((addr + k) & 32'hF)] = d[k];
      end
    end
    cs_high();
  endtask

  task automatic wait_idle();
    while (busy === 1'b1) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  logic [7:0] d [16];

  initial begin
    fork
      begin
        rst_n = 1'b0; sck = 1'b0; mosi = 1'b0; cs_n = 1'b0;
        for (int i = 0; i < 16; i++) d[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R9 reset", miso_oe === 1'b0, miso_oe, 0);
        chk("R8 reset", busy === 1'b0, busy, 0);

        // R1: select held low through reset release; set-latch ignored
        send(8'h06);
        cs_high();
        rd_status("R1", 8'h00);

        // R2: set, clear, and set with an extra bit
        cmd1(8'h06);
        rd_status("R2", 8'h02);
        cmd1(8'h04);
        rd_status("R2", 8'h00);
        cs_low(); send(8'h06); spi_bits(1, 1'b0); cs_high();
        rd_status("R2", 8'h00);

        // R8 / R3: committed three-byte write, status during busy
        cmd1(8'h06);
        d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33;
        wr_array(32'h0010, d, 3, 1'b1);
        chk("R8", busy === 1'b1, busy, 1);
        rd_status("R8", 8'h03);
        wait_idle();
        chk("R8", last_run == WR_CYCLES, last_run, WR_CYCLES);
        rd_status("R8", 8'h00);
        rd_array("R3", 32'h0010, 3);
        rd_array("R3", 32'hFC10, 1);

        // R5: write with latch clear is ignored
        d[0] = 8'h99;
        wr_array(32'h0010, d, 1, 1'b0);
        chk("R5", busy === 1'b0, busy, 0);
        rd_array("R5", 32'h0010, 1);

        // R6: page wrap
        cmd1(8'h06);
        d[0] = 8'hA0; d[1] = 8'hA1; d[2] = 8'hA2; d[3] = 8'hA3;
        wr_array(32'h002E, d, 4, 1'b1);
        wait_idle();
        rd_array("R6", 32'h002E, 2);
        rd_array("R6", 32'h0020, 2);

        // R7: abandoned writes
        cmd1(8'h06);
        d[0] = 8'h55;
        wr_array(32'h0040, d, 1, 1'b1);
        wait_idle();
        cmd1(8'h06);
        cs_low(); send(8'h02); send(8'h00); send(8'h40); send(8'h66);
        spi_bits(3, 1'b1); cs_high();
        chk("R7", busy === 1'b0, busy, 0);
        cs_low(); send(8'h02); send(8'h00); send(8'h40); cs_high();
        chk("R7", busy === 1'b0, busy, 0);
        rd_status("R7", 8'h02);
        rd_array("R7", 32'h0040, 1);

        // R8: commands during busy are ignored
        d[0] = 8'h77;
        wr_array(32'h0050, d, 1, 1'b1);
        d[0] = 8'hEE;
        wr_array(32'h0011, d, 1, 1'b0);
        cmd1(8'h06);
        chk("R8", busy === 1'b1, busy, 1);
        wait_idle();
        rd_status("R8", 8'h00);
        rd_array("R8", 32'h0011, 1);
        rd_array("R8", 32'h0050, 1);

        // R4: read wraps from the top address to zero
        cmd1(8'h06);
        d[0] = 8'hC3;
        wr_array(32'h03FF, d, 1, 1'b1);
        wait_idle();
        cmd1(8'h06);
        d[0] = 8'h3C;
        wr_array(32'h0000, d, 1, 1'b1);
        wait_idle();
        rd_array("R4", 32'h03FF, 3);

        while (rx_q.size() > 0) @(negedge clk);
        chk("scoreboard drained", exp_q.size() == 0, exp_q.size(), 0);
      end
      begin
        repeat (150000) @(negedge clk);
        chk("watchdog", 1'b0, 1, 0);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule